// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit with Byte Reordering

This unit executes one arithmetic or logic operation per accepted request and returns the value to be written back to the destination register. A request carries a 4-bit operation code, a 3-bit class, a source-select bit, a 64-bit destination operand, a 64-bit source-register operand and a 32-bit immediate. One opcode space serves both widths. The class picks either full 64-bit arithmetic or a 32-bit form whose result is zero-extended.

Most operations finish in one cycle. Unsigned divide and modulo use an iterative restoring divider that retires one quotient bit per clock. The byte-order conversion takes its target width (16, 32 or 64 bits) from the immediate and its direction from the source-select bit. A parameter gives the host byte order.

Both edges of the unit are valid/ready streams. A request transfers on a rising clock edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high only when no division is in progress and the single output slot is empty or is being drained in that same cycle. While `out_ready` is low, a presented result stays on `out_data` unchanged. The unit never drops or reorders results.

Top module: `xalu_core`

## Requirements
- R1: While a division is in progress, `in_ready` is low. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value on the next cycle.
- R2: For every operation except divide and modulo, `out_valid` rises on the edge that accepts the request. For divide and modulo (codes 3 and 9), `out_data` becomes valid DATA_W+1 edges after the accepting edge.
- R3: Operation codes are: add 0, subtract 1, multiply 2, divide 3, or 4, and 5, left shift 6, logical right shift 7, negate 8, modulo 9, xor A, move B, arithmetic right shift C, byte-order conversion D. Codes E and F return the destination operand unchanged in all 64 bits. With select 0 the second operand is the immediate sign-extended to 64 bits. With select 1 it is the source register.
- R4: Class 3'b111 works on 64 bits. Any other class value works on the low 32 bits of both operands and zero-extends the result into bits 63:32.
- R5: The shift amount is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class. Code 7 fills with zeros. Code C replicates the sign bit of the selected width.
- R6: Divide and modulo are unsigned. Dividing by zero gives 0. Modulo by zero returns the destination operand, truncated to 32 bits in the 32-bit class.
- R7: Negate returns the two's complement of the destination operand and ignores the immediate and the source register.
- R8: Byte-order conversion ignores the class. An immediate of 16, 32 or 64 sets the width. Select 0 converts to little-endian and select 1 converts to big-endian. With a little-endian host, converting to little-endian keeps the low width bits and zero-extends them. Converting to big-endian reverses the low width/8 bytes and zero-extends them. Any other immediate returns the destination unchanged.
- R9: Multiply returns the low 64 (or, in the 32-bit class, the low 32) bits of the product.
- R10: During reset and right after it is released, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Operation code |
| in_cls | input | 3 | Class: 3'b111 for 64-bit, otherwise 32-bit |
| in_sel | input | 1 | Second-operand select / conversion direction |
| in_dst | input | 64 | Destination operand value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Write-back value |

## Verification
Single-cycle operations are due at the first falling edge after the accepting edge. Divide and modulo are due DATA_W+1 edges after acceptance. The bench logs a due cycle for every request it hands over, and it checks the first cycle in which each result appears against that due cycle. A behavioural model predicts every value, and the bench compares it on each cycle in which `out_valid` is high. Random back-pressure stretches results over several cycles, so the holding rule is checked on every stalled cycle.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_MUL   = 4'h2,
    OP_DIV   = 4'h3,
    OP_OR    = 4'h4,
    OP_AND   = 4'h5,
    OP_LSH   = 4'h6,
    OP_RSH   = 4'h7,
    OP_NEG   = 4'h8,
    OP_MOD   = 4'h9,
    OP_XOR   = 4'hA,
    OP_MOV   = 4'hB,
    OP_ARSH  = 4'hC,
    OP_END   = 4'hD,
    OP_RSV_E = 4'hE,
    OP_RSV_F = 4'hF
  } xalu_op_e;

  localparam logic [2:0] CLS_WIDE = 3'b111;

endpackage

// File: rtl/xalu_arith.sv
module xalu_arith
  import xalu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  xalu_op_e            op,
  input  logic                wide,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   opnd,
  output logic [DATA_W-1:0]   res
);
  localparam int HALF = DATA_W / 2;
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] a, b, lsh, rsh, arsh, raw;
  logic [SH_W-1:0]   sh;
  logic [HALF-1:0]   arsh_n;

  always_comb begin
    a  = wide ? dst  : {{HALF{1'b0}}, dst[HALF-1:0]};
    b  = wide ? opnd : {{HALF{1'b0}}, opnd[HALF-1:0]};
    sh = wide ? opnd[SH_W-1:0] : {1'b0, opnd[SH_W-2:0]};
  end

  assign lsh    = a << sh;
  assign rsh    = a >> sh;
  assign arsh_n = HALF'($signed(a[HALF-1:0]) >>> sh);
  assign arsh   = wide ? DATA_W'($signed(a) >>> sh) : {{HALF{1'b0}}, arsh_n};

  always_comb begin
    unique case (op)
      OP_ADD:  raw = a + b;
      OP_SUB:  raw = a - b;
      OP_MUL:  raw = a * b;
      OP_OR:   raw = a | b;
      OP_AND:  raw = a & b;
      OP_XOR:  raw = a ^ b;
      OP_LSH:  raw = lsh;
      OP_RSH:  raw = rsh;
      OP_ARSH: raw = arsh;
      OP_NEG:  raw = '0 - a;
      OP_MOV:  raw = b;
      default: raw = dst;
    endcase
    if (wide || op == OP_RSV_E || op == OP_RSV_F)
      res = raw;
    else
      res = {{HALF{1'b0}}, raw[HALF-1:0]};
  end

endmodule

// File: rtl/xalu_endian.sv
module xalu_endian #(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 32,
  parameter bit HOST_LE = 1'b1
) (
  input  logic [DATA_W-1:0] val,
  input  logic [IMM_W-1:0]  width_sel,
  input  logic              to_big,
  output logic [DATA_W-1:0] res
);
  localparam int NB    = DATA_W / 8;
  localparam int NUM_W = $clog2(NB);

  logic [DATA_W-1:0] trunc_w [NUM_W];
  logic [DATA_W-1:0] rev_w   [NUM_W];
  logic [NUM_W-1:0]  hit;
  logic              swap;

  generate
    for (genvar k = 0; k < NUM_W; k++) begin : g_width
      localparam int BY = 2 << k;
      logic [DATA_W-1:0] tr, rv;
      always_comb begin
        tr = '0;
        rv = '0;
        for (int j = 0; j < BY; j++) begin
          tr[8*j +: 8] = val[8*j +: 8];
          rv[8*j +: 8] = val[8*(BY-1-j) +: 8];
        end
      end
      assign hit[k]     = (width_sel == IMM_W'(BY * 8));
      assign trunc_w[k] = tr;
      assign rev_w[k]   = rv;
    end
  endgenerate

  assign swap = to_big ^ !HOST_LE;

  always_comb begin
    res = val;
    for (int k = 0; k < NUM_W; k++)
      if (hit[k]) res = swap ? rev_w[k] : trunc_w[k];
  end

endmodule

// File: rtl/xalu_divider.sv
module xalu_divider #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] quo_q, rem_q, dvs_q, dvd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [DATA_W:0]   rem_sh, diff;
  logic              ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[DATA_W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    ge     = rem_sh >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      quo_q  <= dividend;
      rem_q  <= '0;
      dvs_q  <= divisor;
      dvd_q  <= dividend;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q != CNT_W'(DATA_W)) begin
        rem_q <= ge ? diff[DATA_W-1:0] : rem_sh[DATA_W-1:0];
        quo_q <= {quo_q[DATA_W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = busy_q && (cnt_q == CNT_W'(DATA_W));
  assign quotient  = quo_q;
  assign remainder = rem_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= CNT_W'(DATA_W));

  p_rem_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_q != '0) |-> rem_q < dvs_q);

  p_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_q != '0) |-> (quo_q * dvs_q + rem_q) == dvd_q);

  p_zero_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_q == '0) |-> rem_q == dvd_q);

endmodule

// File: rtl/xalu_core.sv
module xalu_core
  import xalu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 32,
  parameter bit HOST_LE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [2:0]        in_cls,
  input  logic              in_sel,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int HALF = DATA_W / 2;

  xalu_op_e          op;
  logic              wide, is_div, accept;
  logic [DATA_W-1:0] opnd, arith_res, end_res, simple_res;
  logic [DATA_W-1:0] dv_dividend, dv_divisor, dv_quo, dv_rem;
  logic              dv_busy, dv_done;
  logic              pend_mod, pend_zero;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;

  assign op     = xalu_op_e'(in_op);
  assign wide   = (in_cls == CLS_WIDE);
  assign opnd   = in_sel ? in_src : {{(DATA_W-IMM_W){in_imm[IMM_W-1]}}, in_imm};
  assign is_div = (op == OP_DIV) || (op == OP_MOD);

  assign in_ready = !dv_busy && (!ov_q || out_ready);
  assign accept   = in_valid && in_ready;

  xalu_arith #(.DATA_W(DATA_W)) u_arith (
    .op   (op),
    .wide (wide),
    .dst  (in_dst),
    .opnd (opnd),
    .res  (arith_res)
  );

  xalu_endian #(.DATA_W(DATA_W), .IMM_W(IMM_W), .HOST_LE(HOST_LE)) u_endian (
    .val       (in_dst),
    .width_sel (in_imm),
    .to_big    (in_sel),
    .res       (end_res)
  );

  assign simple_res  = (op == OP_END) ? end_res : arith_res;
  assign dv_dividend = wide ? in_dst : {{HALF{1'b0}}, in_dst[HALF-1:0]};
  assign dv_divisor  = wide ? opnd   : {{HALF{1'b0}}, opnd[HALF-1:0]};

  xalu_divider #(.DATA_W(DATA_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && is_div),
    .dividend  (dv_dividend),
    .divisor   (dv_divisor),
    .busy      (dv_busy),
    .done      (dv_done),
    .quotient  (dv_quo),
    .remainder (dv_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mod  <= 1'b0;
      pend_zero <= 1'b0;
    end else if (accept && is_div) begin
      pend_mod  <= (op == OP_MOD);
      pend_zero <= (dv_divisor == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (dv_done) begin
      ov_q <= 1'b1;
      od_q <= pend_mod ? dv_rem : (pend_zero ? '0 : dv_quo);
    end else if (accept && !is_div) begin
      ov_q <= 1'b1;
      od_q <= simple_res;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(od_q)));

  p_busy_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dv_busy |-> !in_ready);

  p_single_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_div) |=> ov_q);

  p_div_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dv_done |=> ov_q);

  p_narrow_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wide && !is_div && in_op < 4'hD) |=> od_q[DATA_W-1:HALF] == '0);

  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_done && pend_zero && !pend_mod) |=> od_q == '0);

endmodule

// File: tb/sim_xalu_core.sv
module sim_xalu_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [2:0]  in_cls = '0;
  logic        in_sel = 1'b0;
  logic [63:0] in_dst = '0, in_src = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int n_checks = 0, n_err = 0, cyc = 0;
  bit bp_mode = 1'b0, finished = 1'b0;

  logic [63:0] exp_d[$];
  int          exp_due[$];
  string       exp_tag[$];
  bit          seen = 1'b0, stall_prev = 1'b0;
  logic [63:0] prev_data = '0;

  xalu_core u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [63:0] model(input logic [3:0] op, input logic [2:0] cls, input logic sel,
                                        input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
    logic wide;
    logic [63:0] a, b, r;
    int sh, nb;
    wide = (cls == 3'b111);
    b = sel ? s : {{32{im[31]}}, im};
    if (op == 4'hD) begin
      if (im == 32'd16 || im == 32'd32 || im == 32'd64) begin
        nb = int'(im) / 8;
        r = '0;
        for (int i = 0; i < nb; i++)
          if (sel) r[8*(nb-1-i) +: 8] = d[8*i +: 8];
          else     r[8*i +: 8] = d[8*i +: 8];
        return r;
      end
      return d;
    end
    if (op >= 4'hE) return d;
    a = wide ? d : {32'b0, d[31:0]};
    if (!wide) b = {32'b0, b[31:0]};
    sh = wide ? int'(b[5:0]) : int'(b[4:0]);
    case (op)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h3: r = (b == 0) ? 64'd0 : a / b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'h8: r = -a;
      4'h9: r = (b == 0) ? a : a % b;
      4'hA: r = a ^ b;
      4'hB: r = b;
      default: r = wide ? 64'($signed(a) >>> sh) : {32'b0, 32'($signed(a[31:0]) >>> sh)};
    endcase
    if (!wide) r[63:32] = '0;
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [2:0] cls);
    case (op)
      4'h2: return "R9";
      4'h3, 4'h9: return "R6";
      4'h6, 4'h7, 4'hC: return "R5";
      4'h8: return "R7";
      4'hD: return "R8";
      4'hE, 4'hF: return "R3";
      default: return (cls == 3'b111) ? "R3" : "R4";
    endcase
  endfunction

  // Monitor: compares against the reference queue on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (stall_prev) chk(out_valid && out_data == prev_data, "R1 hold", out_data, prev_data);
      if (out_valid) begin
        if (exp_d.size() == 0) chk(1'b0, "R2 unexpected result", out_data, '0);
        else begin
          chk(out_data == exp_d[0], exp_tag[0], out_data, exp_d[0]);
          if (!seen) begin
            chk(cyc == exp_due[0], "R2 latency", 64'(cyc), 64'(exp_due[0]));
            seen = 1'b1;
          end
        end
      end
      out_ready = bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;
      stall_prev = out_valid && !out_ready;
      prev_data = out_data;
      if (out_valid && out_ready && exp_d.size() > 0) begin
        void'(exp_d.pop_front());
        void'(exp_due.pop_front());
        void'(exp_tag.pop_front());
        seen = 1'b0;
      end
    end
  end

  task automatic send(input logic [3:0] op, input logic [2:0] cls, input logic sel,
                      input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
    bit dv;
    dv = (op == 4'h3 || op == 4'h9);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_cls = cls; in_sel = sel;
    in_dst = d; in_src = s; in_imm = im;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_d.push_back(model(op, cls, sel, d, s, im));
    exp_due.push_back(dv ? cyc + W + 2 : cyc + 1);
    exp_tag.push_back(tag_of(op, cls));
    @(posedge clk);
    #1 in_valid = 1'b0;
    if (dv) begin
      @(negedge clk);
      #1 chk(!in_ready, "R1 busy blocks input", 64'(in_ready), 64'd0);
    end
  endtask

  localparam logic [2:0] C64 = 3'b111, C32 = 3'b100;

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid, "R10 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R10 out_valid after release", 64'(out_valid), 64'd0);
    chk(in_ready, "R10 in_ready after release", 64'(in_ready), 64'd1);

    // R3/R4: sign-extended immediate, width handling
    send(4'h0, C64, 0, 64'd10, 64'd0, 32'hFFFF_FFFF);
    send(4'h1, C32, 1, 64'hAAAA_0000_0000_0001, 64'd2, 32'd0);
    send(4'hB, C32, 0, 64'd0, 64'd0, 32'h8000_0000);
    send(4'hB, C64, 0, 64'd0, 64'd0, 32'h8000_0000);
    send(4'hE, C32, 0, 64'hDEAD_BEEF_0123_4567, 64'd0, 32'd5);
    // R9
    send(4'h2, C64, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 32'd0);
    send(4'h2, C32, 1, 64'h1_8000_0001, 64'h0000_0002, 32'd0);
    // R5 shifts
    send(4'h6, C32, 0, 64'h1, 64'd0, 32'd33);
    send(4'h6, C64, 0, 64'h1, 64'd0, 32'd65);
    send(4'h7, C64, 1, 64'h8000_0000_0000_0000, 64'd63, 32'd0);
    send(4'hC, C32, 0, 64'h0000_0000_8000_0000, 64'd0, 32'd4);
    send(4'hC, C64, 0, 64'h8000_0000_0000_0000, 64'd0, 32'd4);
    // R7
    send(4'h8, C64, 1, 64'd5, 64'h1234, 32'h77);
    send(4'h8, C32, 0, 64'd1, 64'd0, 32'h7FFF);
    // R6 divide/modulo
    send(4'h3, C64, 1, 64'd100, 64'd7, 32'd0);
    send(4'h9, C64, 1, 64'd100, 64'd7, 32'd0);
    send(4'h3, C64, 1, 64'd100, 64'd0, 32'd0);
    send(4'h9, C32, 0, 64'hFFFF_0000_1234_5678, 64'd0, 32'd0);
    send(4'h3, C32, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF);
    // R8 byte order
    send(4'hD, C32, 1, 64'h1122_3344_5566_7788, 64'd0, 32'd16);
    send(4'hD, C64, 1, 64'h1122_3344_5566_7788, 64'd0, 32'd32);
    send(4'hD, C32, 1, 64'h1122_3344_5566_7788, 64'd0, 32'd64);
    send(4'hD, C32, 0, 64'h1122_3344_5566_7788, 64'd0, 32'd16);
    send(4'hD, C64, 0, 64'h1122_3344_5566_7788, 64'd0, 32'd64);
    send(4'hD, C64, 1, 64'h1122_3344_5566_7788, 64'd0, 32'd8);

    // Mixed traffic with back-pressure
    bp_mode = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [3:0]  op;
      logic [31:0] im;
      logic [63:0] s;
      logic        sel;
      op  = 4'($urandom_range(0, 15));
      sel = 1'($urandom_range(0, 1));
      im  = $urandom;
      s   = {$urandom, $urandom};
      if (op == 4'hD) begin
        case ($urandom_range(0, 3))
          0: im = 32'd16;
          1: im = 32'd32;
          2: im = 32'd64;
          default: ;
        endcase
      end
      if ((op == 4'h3 || op == 4'h9) && $urandom_range(0, 3) == 0) begin
        im = '0; s = '0;
      end
      send(op, ($urandom_range(0, 1) != 0) ? C64 : C32, sel, {$urandom, $urandom}, s, im);
    end

    while (exp_d.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule